// File: doc/BRIEF.md
# Multi-Cycle Accumulator Teaching Core

This block is a small processor core that runs each instruction through four single-cycle phases. It fetches 16-bit instruction words from a memory shared by program and data. It holds eight general-purpose registers, a 6-bit instruction pointer, a separate accumulator and three condition flags. Its operations are add, subtract, AND, OR with a memory operand, NOT, and port-mapped input and output.

Sums and differences always land in the accumulator. Logic results, memory-ORed values and input data return to a register. An I/O device is selected by a 6-bit device number on `io_addr`, and each transfer is qualified by a read strobe or a write strobe. The memory port is read-only from the core's side. A word addressed on `mem_addr` appears on `mem_rdata` one clock later.

The sequencer has four states:
- `PH_FETCH` presents the instruction pointer.
- `PH_DECODE` captures the returning word and addresses the operand.
- `PH_EXEC` computes into a holding register.
- `PH_WB` commits the result.

The transitions are PH_FETCH→PH_DECODE→PH_EXEC→PH_WB→PH_FETCH, one per clock. Reset forces PH_FETCH.

Top module: `mc_core`

## Requirements
- R1: Each instruction takes exactly four clocks, in the fixed order fetch, decode, execute, writeback. A synchronous reset (`rst` high) clears the instruction pointer, the accumulator and the flags, returns the sequencer to fetch, and holds `io_rd` and `io_wr` low.
- R2: In fetch, `mem_addr` carries the instruction pointer, and the pointer then advances by one (modulo 64). An instruction word is laid out as opcode in bits 15:12, source field in bits 11:6 and destination field in bits 5:0.
- R3: Opcode values 1 to 7 select ADD, SUB, AND, OR, NOT, IN and OUT. Every other opcode is a no-op that changes no register, accumulator, flag or I/O strobe.
- R4: ADD writes R[src]+R[dst] into the accumulator and leaves the register file unchanged. The accumulator changes only through ADD and SUB.
- R5: SUB writes R[src]−R[dst] (modulo 2^16) into the accumulator and leaves the register file unchanged.
- R6: AND writes R[src] AND R[dst] into R[dst]. NOT writes the complement of R[dst] into R[dst].
- R7: OR reads the memory word whose address is the full 6-bit source field, ORs it with R[dst], and writes the result into R[dst].
- R8: IN drives the source field on `io_addr` with `io_rd` high only during execute. It samples `io_rdata` on the edge that ends execute and writes that value into R[dst].
- R9: OUT drives the destination field on `io_addr` and R[src] on `io_wdata`, with `io_wr` high for exactly one cycle, in writeback.
- R10: `flags` bit 2 is carry, bit 1 is negative and bit 0 is zero. ADD, SUB, AND, OR and NOT set zero when the result is 0 and set negative to the result's bit 15. Only ADD (carry out) and SUB (borrow, i.e. R[src] < R[dst] unsigned) update carry. IN, OUT and no-ops leave all three flags unchanged.
- R11: A register operand is selected by the low 3 bits of its 6-bit field, while memory addresses and device numbers use all 6 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 6 | Shared memory word address |
| mem_rdata | input | 16 | Memory word, valid one cycle after its address |
| io_addr | output | 6 | Device number of the current transfer |
| io_rd | output | 1 | Input strobe, high during execute of IN |
| io_rdata | input | 16 | Data from the addressed device |
| io_wr | output | 1 | Output strobe, one cycle in writeback of OUT |
| io_wdata | output | 16 | Data for the addressed device |
| acc | output | 16 | Accumulator |
| flags | output | 3 | Condition flags {carry, negative, zero} |

## Verification
The bench builds the core with the default parameters: 16-bit words and eight registers. These give 6-bit fields, which allows register operands written as 9 or 17 that must alias onto R1. They also allow device numbers up to 63 and memory operands at addresses far from the program. Unsigned wrap of 0xFFFF+1 and of 5−7 exercises carry and borrow at the word boundary. Per-cycle sampling of a single IN/OUT pair pins down the phase in which each strobe and address appears.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int OPW = 4;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_WB     = 2'd3
    } phase_t;

    typedef enum logic [OPW-1:0] {
        OP_NOP = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_NOT = 4'd5,
        OP_IN  = 4'd6,
        OP_OUT = 4'd7
    } opcode_t;

    typedef struct packed {
        logic c;
        logic n;
        logic z;
    } flags_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = 16
) (
    input  opcode_t         op,
    input  logic [DW-1:0]   src_val,
    input  logic [DW-1:0]   dst_val,
    input  logic [DW-1:0]   mem_val,
    input  logic [DW-1:0]   io_val,
    output logic [DW-1:0]   result,
    output logic            carry
);

    logic [DW:0] wide;

    always_comb begin
        wide = '0;
        unique case (op)
            OP_ADD:  wide = {1'b0, src_val} + {1'b0, dst_val};
            OP_SUB:  wide = {1'b0, src_val} - {1'b0, dst_val};
            OP_AND:  wide = {1'b0, src_val & dst_val};
            OP_OR:   wide = {1'b0, mem_val | dst_val};
            OP_NOT:  wide = {1'b0, ~dst_val};
            OP_IN:   wide = {1'b0, io_val};
            default: wide = {1'b0, dst_val};
        endcase
    end

    assign result = wide[DW-1:0];
    assign carry  = wide[DW];

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [RAW-1:0]  raddr_a,
    output logic [DW-1:0]   rdata_a,
    input  logic [RAW-1:0]  raddr_b,
    output logic [DW-1:0]   rdata_b
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (we && (waddr == RAW'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int FW  = (DW - OPW) / 2,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [FW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic [FW-1:0]   io_addr,
    output logic            io_rd,
    input  logic [DW-1:0]   io_rdata,
    output logic            io_wr,
    output logic [DW-1:0]   io_wdata,
    output logic [DW-1:0]   acc,
    output logic [2:0]      flags
);

    phase_t         ph, ph_nxt;
    logic [FW-1:0]  ip;
    logic [DW-1:0]  ir;
    logic [DW-1:0]  acc_q;
    logic [DW-1:0]  res_q;
    logic           cy_q;
    flags_t         flg;

    opcode_t        op;
    logic [FW-1:0]  fs, fd;
    logic [DW-1:0]  rs_val, rd_val;
    logic [DW-1:0]  alu_res;
    logic           alu_cy;
    logic           rf_we;
    logic           is_arith, is_zn;

    assign op = opcode_t'(ir[DW-1 -: OPW]);
    assign fs = ir[2*FW-1:FW];
    assign fd = ir[FW-1:0];

    assign is_arith = (op == OP_ADD) || (op == OP_SUB);
    assign is_zn    = is_arith || (op == OP_AND) || (op == OP_OR) || (op == OP_NOT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) ph <= PH_FETCH;
        else     ph <= ph_nxt;
    end

    always_comb begin
        unique case (ph)
            PH_FETCH:  ph_nxt = PH_DECODE;
            PH_DECODE: ph_nxt = PH_EXEC;
            PH_EXEC:   ph_nxt = PH_WB;
            PH_WB:     ph_nxt = PH_FETCH;
            default:   ph_nxt = PH_FETCH;
        endcase
    end

    // outputs per phase
    always_comb begin
        mem_addr = fs;
        io_addr  = '0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        rf_we    = 1'b0;
        unique case (ph)
            PH_FETCH:  mem_addr = ip;
            PH_DECODE: mem_addr = mem_rdata[2*FW-1:FW];
            PH_EXEC: begin
                io_rd = (op == OP_IN);
                if (op == OP_IN) io_addr = fs;
            end
            PH_WB: begin
                io_wr = (op == OP_OUT);
                if (op == OP_OUT) io_addr = fd;
                rf_we = (op == OP_AND) || (op == OP_OR) || (op == OP_NOT) || (op == OP_IN);
            end
            default: ;
        endcase
    end

    assign io_wdata = io_wr ? rs_val : '0;

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ip    <= '0;
            ir    <= '0;
            acc_q <= '0;
            res_q <= '0;
            cy_q  <= 1'b0;
            flg   <= '0;
        end else begin
            unique case (ph)
                PH_FETCH:  ip <= ip + 1'b1;
                PH_DECODE: ir <= mem_rdata;
                PH_EXEC: begin
                    res_q <= alu_res;
                    cy_q  <= alu_cy;
                end
                PH_WB: begin
                    if (is_arith) begin
                        acc_q <= res_q;
                        flg.c <= cy_q;
                    end
                    if (is_zn) begin
                        flg.z <= (res_q == '0);
                        flg.n <= res_q[DW-1];
                    end
                end
                default: ;
            endcase
        end
    end

    mc_alu #(.DW(DW)) i_alu (
        .op      (op),
        .src_val (rs_val),
        .dst_val (rd_val),
        .mem_val (mem_rdata),
        .io_val  (io_rdata),
        .result  (alu_res),
        .carry   (alu_cy)
    );

    mc_regfile #(.DW(DW), .NREG(NREG)) i_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (fd[RAW-1:0]),
        .wdata   (res_q),
        .raddr_a (fs[RAW-1:0]),
        .rdata_a (rs_val),
        .raddr_b (fd[RAW-1:0]),
        .rdata_b (rd_val)
    );

    assign acc   = acc_q;
    assign flags = flg;

    // R1: phase order
    a_r1_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FETCH) |=> (ph == PH_DECODE));
    a_r1_wb_then_fetch: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WB) |=> (ph == PH_FETCH));
    // R2: pointer moves only in fetch, by one
    a_r2_ip_step: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FETCH) |=> (ip == $past(ip) + 1'b1));
    a_r2_ip_hold: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_FETCH) |=> $stable(ip));
    // R4: accumulator only moves after an arithmetic writeback
    a_r4_acc_arith_only: assert property (@(posedge clk) disable iff (rst)
        !(ph == PH_WB && is_arith) |=> $stable(acc_q));
    // R8: input strobe only in execute
    a_r8_rd_in_exec: assert property (@(posedge clk) disable iff (rst)
        io_rd |-> (ph == PH_EXEC));
    // R9: output strobe is a single-cycle pulse
    a_r9_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        io_wr |=> !io_wr);
    // R10: flags hold across non-flag instructions
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WB && !is_zn) |=> $stable(flg));

endmodule

// File: tb/test_mc_core.sv
module test_mc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic [5:0]  io_addr;
    logic        io_rd;
    logic [15:0] io_rdata;
    logic        io_wr;
    logic [15:0] io_wdata;
    logic [15:0] acc;
    logic [2:0]  flags;

    logic [15:0] mem [64];
    logic [15:0] dev [64];
    logic [15:0] out_val [16];
    logic [5:0]  out_dev [16];
    int          out_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    mc_core i_mc_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .io_addr   (io_addr),
        .io_rd     (io_rd),
        .io_rdata  (io_rdata),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .acc       (acc),
        .flags     (flags)
    );

    always @(posedge clk) mem_rdata <= mem[mem_addr];
    assign io_rdata = dev[io_addr];

    always @(posedge clk) begin
        if (!rst && io_wr) begin
            if (out_cnt < 16) begin
                out_val[out_cnt] = io_wdata;
                out_dev[out_cnt] = io_addr;
            end
            out_cnt++;
        end
    end

    function automatic logic [15:0] ins(int op, int s, int d);
        return {op[3:0], s[5:0], d[5:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 64; i++) begin
            mem[i] = 16'h0;
            dev[i] = 16'h0;
        end
    endtask

    task automatic restart();
        @(negedge clk);
        rst = 1'b1;
        out_cnt = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(int n);
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset acc", acc, 0);
        chk("R1 reset flags", flags, 0);
        chk("R1 reset ip on mem_addr", mem_addr, 0);
        chk("R1 reset io_rd", io_rd, 0);
        chk("R1 reset io_wr", io_wr, 0);
    endtask

    task automatic t_timing();
        clear_all();
        dev[3] = 16'hBEEF;
        mem[0] = ins(6, 3, 5);
        mem[1] = ins(7, 5, 12);
        restart();
        chk("R2 fetch addr k0", mem_addr, 0);
        chk("R1 no io_rd in fetch", io_rd, 0);
        @(negedge clk);
        chk("R8 no io_rd in decode", io_rd, 0);
        @(negedge clk);
        chk("R8 io_rd in execute", io_rd, 1);
        chk("R8 io_addr device", io_addr, 3);
        @(negedge clk);
        chk("R8 io_rd off in wb", io_rd, 0);
        chk("R9 no io_wr for IN", io_wr, 0);
        @(negedge clk);
        chk("R2 fetch addr k4", mem_addr, 1);
        repeat (2) @(negedge clk);
        chk("R9 no io_wr in execute", io_wr, 0);
        @(negedge clk);
        chk("R9 io_wr in wb", io_wr, 1);
        chk("R9 io_addr dst field", io_addr, 12);
        chk("R9 io_wdata", io_wdata, 16'hBEEF);
        @(negedge clk);
        chk("R9 io_wr single cycle", io_wr, 0);
        chk("R2 fetch addr k8", mem_addr, 2);
    endtask

    task automatic t_add();
        clear_all();
        dev[1] = 16'h1234;
        dev[2] = 16'h0F0F;
        mem[0] = ins(6, 1, 1);
        mem[1] = ins(6, 2, 2);
        mem[2] = ins(1, 1, 2);
        mem[3] = ins(7, 1, 9);
        mem[4] = ins(7, 2, 10);
        restart();
        run(5);
        chk("R4 add acc", acc, 16'h2143);
        chk("R10 add flags", flags, 3'b000);
        chk("R9 out count", out_cnt, 2);
        chk("R4 R1 unchanged", out_val[0], 16'h1234);
        chk("R4 R2 unchanged", out_val[1], 16'h0F0F);
        chk("R9 out device", out_dev[0], 9);
    endtask

    task automatic t_carry();
        clear_all();
        dev[1] = 16'hFFFF;
        dev[2] = 16'h0001;
        mem[0] = ins(6, 1, 1);
        mem[1] = ins(6, 2, 2);
        mem[2] = ins(1, 1, 2);
        mem[3] = ins(6, 1, 3);
        mem[4] = ins(7, 3, 4);
        restart();
        run(3);
        chk("R4 add wrap acc", acc, 16'h0000);
        chk("R10 add carry zero", flags, 3'b101);
        run(2);
        chk("R10 in/out keep flags", flags, 3'b101);
        chk("R8 in value", out_val[0], 16'hFFFF);
    endtask

    task automatic t_sub();
        clear_all();
        dev[1] = 16'd5;
        dev[2] = 16'd7;
        mem[0] = ins(6, 1, 1);
        mem[1] = ins(6, 2, 2);
        mem[2] = ins(2, 1, 2);
        mem[3] = ins(2, 2, 1);
        mem[4] = ins(2, 1, 1);
        restart();
        run(3);
        chk("R5 sub negative acc", acc, 16'hFFFE);
        chk("R10 sub borrow neg", flags, 3'b110);
        run(1);
        chk("R5 sub positive acc", acc, 16'h0002);
        chk("R10 sub no borrow", flags, 3'b000);
        run(1);
        chk("R5 sub equal acc", acc, 16'h0000);
        chk("R10 sub zero", flags, 3'b001);
    endtask

    task automatic t_logic();
        clear_all();
        dev[6] = 16'hFFFF;
        dev[7] = 16'h0001;
        dev[1] = 16'hF0F0;
        dev[2] = 16'hFF00;
        mem[0] = ins(6, 6, 6);
        mem[1] = ins(6, 7, 7);
        mem[2] = ins(1, 6, 7);
        mem[3] = ins(6, 1, 1);
        mem[4] = ins(6, 2, 2);
        mem[5] = ins(3, 1, 2);
        mem[6] = ins(7, 2, 4);
        mem[7] = ins(5, 0, 1);
        mem[8] = ins(7, 1, 5);
        restart();
        run(7);
        chk("R6 and result", out_val[0], 16'hF000);
        chk("R10 and flags keep carry", flags, 3'b110);
        chk("R4 acc untouched by and", acc, 16'h0000);
        run(2);
        chk("R6 not result", out_val[1], 16'h0F0F);
        chk("R10 not flags", flags, 3'b100);
    endtask

    task automatic t_or();
        clear_all();
        mem[40] = 16'h00F0;
        mem[41] = 16'hFFFF;
        mem[8]  = 16'hFFFF;
        dev[1]  = 16'h0F00;
        mem[0] = ins(6, 1, 3);
        mem[1] = ins(4, 40, 3);
        mem[2] = ins(7, 3, 2);
        restart();
        run(3);
        chk("R7 or memory operand", out_val[0], 16'h0FF0);
        chk("R10 or flags", flags, 3'b000);
    endtask

    task automatic t_nop();
        clear_all();
        dev[1] = 16'h8000;
        dev[2] = 16'h8000;
        mem[0] = ins(6, 1, 1);
        mem[1] = ins(6, 2, 2);
        mem[2] = ins(1, 1, 2);
        mem[3] = ins(0, 1, 2);
        mem[4] = ins(8, 1, 1);
        mem[5] = ins(15, 2, 2);
        mem[6] = ins(7, 1, 7);
        mem[7] = ins(7, 2, 7);
        restart();
        run(6);
        chk("R3 nop acc kept", acc, 16'h0000);
        chk("R3 nop flags kept", flags, 3'b101);
        chk("R3 nop no output", out_cnt, 0);
        run(2);
        chk("R3 R1 kept", out_val[0], 16'h8000);
        chk("R3 R2 kept", out_val[1], 16'h8000);
    endtask

    task automatic t_index();
        clear_all();
        dev[5]  = 16'h5A5A;
        dev[45] = 16'hC3C3;
        mem[0] = ins(6, 5, 9);
        mem[1] = ins(7, 1, 6);
        mem[2] = ins(7, 17, 6);
        mem[3] = ins(6, 45, 12);
        mem[4] = ins(7, 4, 63);
        restart();
        run(5);
        chk("R11 field 9 is R1", out_val[0], 16'h5A5A);
        chk("R11 field 17 is R1", out_val[1], 16'h5A5A);
        chk("R11 device 45", out_val[2], 16'hC3C3);
        chk("R11 device 63", out_dev[2], 63);
    endtask

    initial begin
        clear_all();
        t_reset();
        t_timing();
        t_add();
        t_carry();
        t_sub();
        t_logic();
        t_or();
        t_nop();
        t_index();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule